// File: doc/BRIEF.md
# UART Register Front-End

This block is the processor-facing side of a small serial port. It sits on a simple 32-bit read/write port with per-byte write strobes and answers a fixed, aliased address window. Inside the window it exposes three word registers: a status/control word, a baud scaler word and a data word. The serial shifters, baud timing, parity logic and transmit queue live elsewhere. This block only holds their settings and passes bytes in and out.

Bytes arriving from the receive side enter through a byte port and a valid strobe. They are stored in a circular receive FIFO whose depth is a parameter. A read of the data word pops the oldest byte. A write of the data word sends its low byte to a transmit output with a one-cycle strobe. While the receive-interrupt enable bit is set, accepted bytes raise an interrupt line. The line stays high until the FIFO is drained by reads or software clears the enable.

Every bus request is taken in one cycle. Read data and its valid flag come back registered, one clock after the request.

Top module: `uart_regfront`

## Requirements
- R1: After reset the status/control word reads 0x00000022, the scaler reads 0, and both `irq` and `tx_valid` are low.
- R2: A read request (`bus_req`=1, `bus_we`=0) makes `bus_rvalid` high with `bus_rdata` in the following cycle. `bus_rvalid` is low in every cycle that does not follow a read request.
- R3: The word index is ((`bus_addr` − `BASE_ADDR`) AND (`WIN_BYTES` − 1)) / 4. Index 0 is status/control, index 1 is the scaler and index 4 is data. Addresses one window apart reach the same word.
- R4: A write with at least one `bus_wstrb` bit set replaces the whole status/control word (index 0) or the whole scaler (index 1) with `bus_wdata`. A write with `bus_wstrb`=0 changes nothing.
- R5: A status read returns the stored word with bit 1 (transmit empty) forced to 1 and bit 5 (receive empty) set exactly when the receive FIFO holds no byte. All other bits read back as last written; bit 13 is the receive-interrupt enable.
- R6: A data read returns the oldest received byte zero-extended to 32 bits and removes it from the FIFO, in arrival order across pointer wrap-around. On an empty FIFO it returns 0 and changes nothing.
- R7: A read of any index other than 0, 1 or 4 returns 0xFFFFFFFF. A write to such an index has no effect.
- R8: A byte on `rx_data` with `rx_valid` is stored only when the FIFO occupancy at the start of that cycle is below `DEPTH`; otherwise it is dropped. A byte push and a data-read pop in the same cycle both take effect.
- R9: A data-word write with any strobe set drives `tx_data` = `bus_wdata`[7:0] with `tx_valid` high for exactly the following cycle. Such a write does not enter the receive FIFO.
- R10: `irq` rises in the cycle after a byte is accepted while bit 13 is set. It stays high until a data read leaves the FIFO empty or bit 13 is written to 0, and is never high while bit 13 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte-lane write strobes |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Receive interrupt |

## Verification
Some rules are checked by the embedded assertions on every cycle:
- the one-cycle read response;
- the bound on FIFO occupancy;
- the full FIFO dropping pushes and an empty FIFO ignoring pops;
- an equal push and pop leaving the count unchanged;
- `irq` never being high without its enable, and rising only after an accepted byte;
- `tx_valid` only following a write.

Other behaviour is visible only in the bench's directed scenarios:
- byte ordering through pointer wrap-around;
- the exact values read back from status, scaler and unmapped words;
- address aliasing;
- the interrupt falling when the last byte is read.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

  // status/control bit positions (software decodes these)
  localparam int ST_TX_FULL   = 0;
  localparam int ST_TX_EMPTY  = 1;
  localparam int ST_RX_FULL   = 4;
  localparam int ST_RX_EMPTY  = 5;
  localparam int ST_PAR_ERR   = 8;
  localparam int ST_STOP_ERR  = 9;
  localparam int CT_RX_IE     = 13;
  localparam int CT_TX_IE     = 14;
  localparam int CT_PAR_EN    = 15;

  localparam logic [31:0] STATUS_RESET = 32'h0000_0022;
  localparam logic [31:0] UNMAPPED_RD  = 32'hFFFF_FFFF;

  // word indices inside the window
  localparam int IDX_STATUS = 0;
  localparam int IDX_SCALER = 1;
  localparam int IDX_DATA   = 4;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_SCALER,
    SEL_DATA
  } reg_sel_e;

endpackage

// File: rtl/uart_rf_decode.sv
module uart_rf_decode
  import uart_rf_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  parameter int                WIN_BYTES = 4096
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);

  localparam int                WIN_LOG = $clog2(WIN_BYTES);
  localparam int                IDX_W   = WIN_LOG - 2;
  localparam logic [ADDR_W-1:0] MASK    = ADDR_W'(WIN_BYTES - 1);

  logic [ADDR_W-1:0] offset;
  logic [IDX_W-1:0]  idx;

  always_comb begin
    offset = (addr - BASE_ADDR) & MASK;
    idx    = offset[WIN_LOG-1:2];
    if (idx == IDX_W'(IDX_STATUS))      sel = SEL_STATUS;
    else if (idx == IDX_W'(IDX_SCALER)) sel = SEL_SCALER;
    else if (idx == IDX_W'(IDX_DATA))   sel = SEL_DATA;
    else                                sel = SEL_NONE;
  end

endmodule

// File: rtl/uart_rf_rxfifo.sv
module uart_rf_rxfifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        push,
  input  logic [DATA_W-1:0]           push_data,
  input  logic                        pop_req,
  output logic                        push_ok,
  output logic                        pop_ok,
  output logic [DATA_W-1:0]           head,
  output logic                        empty,
  output logic                        last_one,
  output logic [$clog2(DEPTH+1)-1:0]  count
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  cnt_q;

  assign empty    = (cnt_q == '0);
  assign last_one = (cnt_q == CNT_W'(1));
  assign push_ok  = push && (cnt_q != FULL_CNT);
  assign pop_ok   = pop_req && !empty;
  assign head     = mem[rd_ptr];
  assign count    = cnt_q;

  // storage: write port only, no reset, so RAM can be inferred
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL_CNT); // R8
  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == FULL_CNT && !pop_req) |=> cnt_q == FULL_CNT); // R8
  AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (empty && !push) |=> cnt_q == '0); // R6
  AST_PUSHPOP_BALANCED: assert property (@(posedge clk) disable iff (rst)
    (push_ok && pop_ok) |=> $stable(cnt_q)); // R8

endmodule

// File: rtl/uart_rf_ctrl.sv
module uart_rf_ctrl
  import uart_rf_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_status,
  input  logic             wr_scaler,
  input  logic [REG_W-1:0] wdata,
  input  logic             rx_accepted,
  input  logic             rx_drained,
  output logic [REG_W-1:0] status_q,
  output logic [REG_W-1:0] scaler_q,
  output logic             irq
);

  logic [REG_W-1:0] status_d;
  logic             irq_d;

  always_comb begin
    status_d = wr_status ? wdata : status_q;
    // the enable that will hold after this cycle gates the line
    irq_d = ((irq && !rx_drained) || (rx_accepted && status_q[CT_RX_IE]))
            && status_d[CT_RX_IE];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= REG_W'(STATUS_RESET);
      scaler_q <= '0;
      irq      <= 1'b0;
    end else begin
      status_q <= status_d;
      if (wr_scaler) scaler_q <= wdata;
      irq <= irq_d;
    end
  end

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    irq |-> status_q[CT_RX_IE]); // R10
  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(rx_accepted)); // R10

endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_rf_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h4000_0000,
  parameter int                WIN_BYTES = 4096,
  parameter int                DEPTH     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [3:0]        bus_wstrb,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              irq
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  reg_sel_e         sel;
  logic             rd_en, wr_en;
  logic             push_ok, pop_ok, fifo_empty, fifo_last;
  logic [7:0]       fifo_head;
  logic [CNT_W-1:0] fifo_count;
  logic [31:0]      status_q, scaler_q;
  logic [31:0]      rdata_d;

  assign rd_en = bus_req && !bus_we;
  assign wr_en = bus_req && bus_we && (bus_wstrb != 4'b0000);

  uart_rf_decode #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR),
    .WIN_BYTES (WIN_BYTES)
  ) u_decode (
    .addr (bus_addr),
    .sel  (sel)
  );

  uart_rf_rxfifo #(
    .DEPTH  (DEPTH),
    .DATA_W (8)
  ) u_rxfifo (
    .clk       (clk),
    .rst       (rst),
    .push      (rx_valid),
    .push_data (rx_data),
    .pop_req   (rd_en && sel == SEL_DATA),
    .push_ok   (push_ok),
    .pop_ok    (pop_ok),
    .head      (fifo_head),
    .empty     (fifo_empty),
    .last_one  (fifo_last),
    .count     (fifo_count)
  );

  uart_rf_ctrl #(
    .REG_W (32)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .wr_status   (wr_en && sel == SEL_STATUS),
    .wr_scaler   (wr_en && sel == SEL_SCALER),
    .wdata       (bus_wdata),
    .rx_accepted (push_ok),
    .rx_drained  (pop_ok && fifo_last && !push_ok),
    .status_q    (status_q),
    .scaler_q    (scaler_q),
    .irq         (irq)
  );

  // read mux
  always_comb begin
    unique case (sel)
      SEL_STATUS: begin
        rdata_d              = status_q;
        rdata_d[ST_TX_EMPTY] = 1'b1;
        rdata_d[ST_RX_EMPTY] = fifo_empty;
      end
      SEL_SCALER: rdata_d = scaler_q;
      SEL_DATA:   rdata_d = pop_ok ? {24'h0, fifo_head} : 32'h0;
      default:    rdata_d = UNMAPPED_RD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      tx_valid   <= 1'b0;
      tx_data    <= '0;
    end else begin
      bus_rvalid <= rd_en;
      if (rd_en) bus_rdata <= rdata_d;
      tx_valid <= wr_en && sel == SEL_DATA;
      if (wr_en && sel == SEL_DATA) tx_data <= bus_wdata[7:0];
    end
  end

  AST_READ_ANSWERS: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> bus_rvalid); // R2
  AST_RVALID_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> $past(rd_en)); // R2
  AST_TX_ONLY_WRITE: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> $past(bus_req && bus_we)); // R9
  AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == SEL_DATA && fifo_count == '0) |=> bus_rdata == 32'h0); // R6

endmodule

// File: tb/uart_regfront_tb.sv
module uart_regfront_tb;

  localparam logic [31:0] BASE  = 32'h4000_0000;
  localparam int          WIN   = 4096;
  localparam int          DEPTH = 16;
  localparam logic [31:0] A_STAT = BASE;
  localparam logic [31:0] A_SCAL = BASE + 32'd4;
  localparam logic [31:0] A_DATA = BASE + 32'd16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic [3:0]  bus_wstrb = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        irq;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  uart_regfront #(
    .ADDR_W (32), .BASE_ADDR (BASE), .WIN_BYTES (WIN), .DEPTH (DEPTH)
  ) u_dut (
    .clk (clk), .rst (rst),
    .bus_req (bus_req), .bus_we (bus_we), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_wstrb (bus_wstrb),
    .bus_rdata (bus_rdata), .bus_rvalid (bus_rvalid),
    .rx_valid (rx_valid), .rx_data (rx_data),
    .tx_valid (tx_valid), .tx_data (tx_data), .irq (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    chk("R2 rvalid", 32'(bus_rvalid), 32'd1);
    d = bus_rdata;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_wstrb = s;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0; bus_wstrb = '0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 tx_valid", 32'(tx_valid), 32'd0);
    chk("R2 rvalid idle", 32'(bus_rvalid), 32'd0);
    rd(A_STAT, d); chk("R1 status", d, 32'h22);
    rd(A_SCAL, d); chk("R1 scaler", d, 32'h0);
    @(negedge clk);
    chk("R2 rvalid drops", 32'(bus_rvalid), 32'd0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(A_SCAL, 32'h1234_5678, 4'hF);
    rd(A_SCAL, d); chk("R4 scaler write", d, 32'h1234_5678);
    wr(A_SCAL, 32'hDEAD_BEEF, 4'h0);
    rd(A_SCAL, d); chk("R4 zero strobe ignored", d, 32'h1234_5678);
    wr(A_SCAL, 32'h0BAD_F00D, 4'b0010);
    rd(A_SCAL, d); chk("R4 one strobe full word", d, 32'h0BAD_F00D);
    wr(A_STAT, 32'h0000_A311, 4'b0001);
    rd(A_STAT, d); chk("R5 forced empty bits", d, 32'h0000_A333);
    push(8'h77);
    rd(A_STAT, d); chk("R5 rx empty clear", d, 32'h0000_A313);
    rd(A_DATA, d); chk("R6 pop", d, 32'h77);
    wr(A_STAT, 32'h0, 4'hF);
    rd(A_STAT, d); chk("R5 cleared word", d, 32'h22);
  endtask

  task automatic t_decode();
    logic [31:0] d;
    rd(BASE + WIN + 4, d); chk("R3 alias scaler", d, 32'h0BAD_F00D);
    rd(BASE - WIN, d);     chk("R3 alias status below", d, 32'h22);
    rd(BASE + 8, d);       chk("R7 unmapped 2", d, 32'hFFFF_FFFF);
    rd(BASE + 12, d);      chk("R7 unmapped 3", d, 32'hFFFF_FFFF);
    rd(BASE + 20, d);      chk("R7 unmapped 5", d, 32'hFFFF_FFFF);
    wr(BASE + 8, 32'h0000_0000, 4'hF);
    wr(BASE + 20, 32'h55, 4'hF);
    chk("R7 no tx on unmapped", 32'(tx_valid), 32'd0);
    rd(A_SCAL, d); chk("R7 scaler untouched", d, 32'h0BAD_F00D);
    rd(A_STAT, d); chk("R7 status untouched", d, 32'h22);
  endtask

  task automatic t_fifo_wrap();
    logic [31:0] d;
    for (int i = 0; i < 10; i++) push(8'(i));
    for (int i = 0; i < 10; i++) begin
      rd(A_DATA, d); chk("R6 order", d, 32'(i));
    end
    for (int i = 0; i < DEPTH + 1; i++) push(8'(8'hA0 + i));
    rd(A_STAT, d); chk("R5 full not empty", d & 32'h20, 32'h0);
    for (int i = 0; i < DEPTH; i++) begin
      rd(A_DATA, d); chk("R6 wrap order", d, 32'(8'hA0 + i));
    end
    rd(A_DATA, d); chk("R8 overflow dropped", d, 32'h0);
    rd(A_DATA, d); chk("R6 empty read zero", d, 32'h0);
    rd(A_STAT, d); chk("R5 empty again", d, 32'h22);
  endtask

  task automatic t_simul();
    logic [31:0] d;
    push(8'h11);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = A_DATA; rx_valid = 1'b1; rx_data = 8'h22;
    @(negedge clk);
    bus_req = 1'b0; rx_valid = 1'b0;
    chk("R8 simul pop value", bus_rdata, 32'h11);
    rd(A_DATA, d); chk("R8 simul push kept", d, 32'h22);
    rd(A_DATA, d); chk("R8 simul then empty", d, 32'h0);
    // empty FIFO: read and push together, read returns 0, byte kept
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = A_DATA; rx_valid = 1'b1; rx_data = 8'h33;
    @(negedge clk);
    bus_req = 1'b0; rx_valid = 1'b0;
    chk("R6 empty read with push", bus_rdata, 32'h0);
    rd(A_DATA, d); chk("R8 byte after empty read", d, 32'h33);
    // full FIFO: push dropped even with a pop in the same cycle
    for (int i = 0; i < DEPTH; i++) push(8'(8'h40 + i));
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = A_DATA; rx_valid = 1'b1; rx_data = 8'hEE;
    @(negedge clk);
    bus_req = 1'b0; rx_valid = 1'b0;
    chk("R8 full pop value", bus_rdata, 32'h40);
    for (int i = 1; i < DEPTH; i++) begin
      rd(A_DATA, d); chk("R8 full rest", d, 32'(8'h40 + i));
    end
    rd(A_DATA, d); chk("R8 full push dropped", d, 32'h0);
  endtask

  task automatic t_tx();
    logic [31:0] d;
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = A_DATA; bus_wdata = 32'hABCD_EF5A; bus_wstrb = 4'b0001;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0; bus_wstrb = '0;
    chk("R9 tx_valid", 32'(tx_valid), 32'd1);
    chk("R9 tx_data", 32'(tx_data), 32'h5A);
    @(negedge clk);
    chk("R9 tx_valid one cycle", 32'(tx_valid), 32'd0);
    wr(A_DATA, 32'h66, 4'h0);
    chk("R9 no tx zero strobe", 32'(tx_valid), 32'd0);
    rd(A_STAT, d); chk("R9 tx not looped to rx", d, 32'h22);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    push(8'h01);
    chk("R10 no irq when disabled", 32'(irq), 32'd0);
    rd(A_DATA, d);
    wr(A_STAT, 32'h0000_2000, 4'hF);
    chk("R10 enable alone no irq", 32'(irq), 32'd0);
    push(8'h02);
    chk("R10 irq rises", 32'(irq), 32'd1);
    push(8'h03);
    rd(A_DATA, d); chk("R10 data", d, 32'h02);
    chk("R10 irq held", 32'(irq), 32'd1);
    rd(A_DATA, d); chk("R10 data last", d, 32'h03);
    chk("R10 irq falls on drain", 32'(irq), 32'd0);
    push(8'h04);
    chk("R10 irq again", 32'(irq), 32'd1);
    wr(A_STAT, 32'h0, 4'hF);
    chk("R10 irq cleared by enable", 32'(irq), 32'd0);
    rd(A_DATA, d); chk("R10 drain", d, 32'h04);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_decode();
    t_fifo_wrap();
    t_simul();
    t_tx();
    t_irq();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule